// File: doc/BRIEF.md
# Toggle-Bit Status Decoder for Parallel NOR Flash

This block runs on the host side of a parallel NOR flash. It works out how far an embedded program or erase operation has progressed by using the flash's legacy polling behaviour. The block does not read a status register. It reads one word address several times and looks for bits that change between reads. A single-cycle start pulse launches one evaluation. The block then issues reads through a plain request/response port and waits for each response. When it has an answer, it reports one result code together with a one-cycle completion strobe.

The answer takes two phases. In the first phase the block makes three reads and watches bit 6. If bit 6 is toggling, the operation is still running, and the block reports busy, timeout or write-buffer abort. It chooses between these from bits of the first read and from a flag that says a write-buffer program was issued. If bit 6 is steady, the block makes two more reads and compares bit 2 between them. A change in bit 2 means the operation is suspended; no change means the flash is ready. If the result is timeout, the host must send a software reset to the flash. The flash may then keep reporting busy for up to about 2 µs, so the host should expect a few more busy results before ready.

Top module: `nor_poll_decoder`

## Requirements
- R1: After reset, `done_o` and `rd_req_o` are low and the block is idle.
- R2: A start pulse while idle begins an evaluation. Each read is a one-cycle `rd_req_o` pulse. The next request comes only after the previous response. Every read of an evaluation uses the `addr_i` value sampled with the start pulse.
- R3: Read data is captured only when `rsp_valid_i` is high while a read is outstanding, meaning after its request cycle. At any other time `rsp_valid_i` is ignored.
- R4: After three reads, bit 6 counts as toggling only if it differs between reads 1 and 2 and also between reads 2 and 3. When it toggles, the evaluation ends after exactly three reads.
- R5: If bit 6 toggles, `wbuf_i` was high with the start pulse, and bit 1 of read 1 is set, the result is write-buffer abort (code 4). This holds even when the timeout condition is also present.
- R6: If bit 6 toggles and abort does not apply, bit 5 of read 1 gives timeout (code 3). Otherwise the result is busy (code 0). Bit 5 or bit 1 in any read other than the first has no effect.
- R7: If bit 6 does not toggle, exactly two more reads are made, for five in total. The result is suspended (code 2) if bit 2 differs between reads 4 and 5, and ready (code 1) if it does not.
- R8: `done_o` is high for exactly one cycle per evaluation. `result_o` carries a code from 0 to 4 in that cycle.
- R9: A start pulse while an evaluation is running is ignored. This includes the cycle in which `done_o` is high: no further reads follow once it has finished.
- R10: There is no limit on how long the block waits for a response. Any response latency of one cycle or more gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run an evaluation |
| addr_i | input | ADDR_W | Word address to poll, sampled with start |
| wbuf_i | input | 1 | Write-buffer program in progress, sampled with start |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Address of the read |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | DATA_W | Read response data word |
| done_o | output | 1 | Result strobe |
| result_o | output | 3 | Result code: 0 busy, 1 ready, 2 suspended, 3 timeout, 4 abort |

## Verification
Two kinds of collision can fall in the same cycle, and both are provoked on purpose. The first is between the abort and timeout decisions. A read carries both bit 1 and bit 5 while the write-buffer flag is set, and the bench expects abort. A second case sets bit 1 without the flag and expects busy. The second collision is between the completion strobe and a new start pulse. The bench raises start in the very cycle `done_o` is high, and again in the middle of a read. It then expects the exact read count and no further `rd_req_o` for several cycles. A stray response during a request cycle carries data that would flip the outcome, so the bench can tell whether it was captured.

// File: rtl/nps_pkg.sv
package nps_pkg;

  // Result codes reported on result_o
  typedef enum logic [2:0] {
    RES_BUSY  = 3'd0,
    RES_READY = 3'd1,
    RES_SUSP  = 3'd2,
    RES_TMO   = 3'd3,
    RES_ABORT = 3'd4
  } res_e;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EVAL1 = 3'd3,
    ST_EVAL2 = 3'd4,
    ST_DONE  = 3'd5
  } seq_e;

  // Reads in the toggle phase and in the whole evaluation
  localparam int unsigned FIRST_READS = 3;
  localparam int unsigned TOTAL_READS = 5;

endpackage

// File: rtl/nps_sample_bank.sv
module nps_sample_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DEPTH*DATA_W-1:0] words
);

  // One holding register per read slot, each with its own enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign words[g*DATA_W +: DATA_W] = slot_q;
  end

endmodule

// File: rtl/nps_toggle_eval.sv
module nps_toggle_eval
  import nps_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DEPTH    = 5,
  parameter int unsigned TGL_BIT  = 6,
  parameter int unsigned TMO_BIT  = 5,
  parameter int unsigned SUSP_BIT = 2,
  parameter int unsigned ABT_BIT  = 1
) (
  input  logic [DEPTH*DATA_W-1:0] words,
  input  logic                    wbuf,
  output logic                    toggling,
  output res_e                    fast_code,
  output res_e                    slow_code
);

  logic [DATA_W-1:0] rd [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign rd[g] = words[g*DATA_W +: DATA_W];
  end

  logic diff_a;
  logic diff_b;
  logic susp_diff;
  logic abort_hit;
  logic tmo_hit;

  always_comb begin
    diff_a    = rd[0][TGL_BIT] ^ rd[1][TGL_BIT];
    diff_b    = rd[1][TGL_BIT] ^ rd[2][TGL_BIT];
    toggling  = diff_a & diff_b;
    abort_hit = wbuf & rd[0][ABT_BIT];
    tmo_hit   = rd[0][TMO_BIT];
    susp_diff = rd[3][SUSP_BIT] ^ rd[4][SUSP_BIT];
  end

  // Fixed order: abort wins over timeout, timeout over busy
  always_comb begin
    if (abort_hit) begin
      fast_code = RES_ABORT;
    end else if (tmo_hit) begin
      fast_code = RES_TMO;
    end else begin
      fast_code = RES_BUSY;
    end
  end

  always_comb begin
    slow_code = susp_diff ? RES_SUSP : RES_READY;
  end

endmodule

// File: rtl/nps_read_seq.sv
module nps_read_seq
  import nps_pkg::*;
#(
  parameter int unsigned N_FIRST = FIRST_READS,
  parameter int unsigned N_TOTAL = TOTAL_READS,
  localparam int unsigned IDX_W  = $clog2(N_TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rsp_valid,
  input  logic             toggling,
  input  res_e             fast_code,
  input  res_e             slow_code,
  output logic             launch,
  output logic             rd_req,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             done,
  output res_e             result
);

  seq_e             state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_inc;
  logic             idx_en;
  res_e             res_q, res_d;
  logic             res_en;

  assign idx_inc = idx_q + IDX_W'(1);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    res_d   = res_q;
    res_en  = 1'b0;
    launch  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          launch  = 1'b1;
          idx_d   = '0;
          idx_en  = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          cap_en = 1'b1;
          idx_d  = idx_inc;
          idx_en = 1'b1;
          if (idx_inc == IDX_W'(N_FIRST)) begin
            state_d = ST_EVAL1;
          end else if (idx_inc == IDX_W'(N_TOTAL)) begin
            state_d = ST_EVAL2;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      ST_EVAL1: begin
        if (toggling) begin
          res_d   = fast_code;
          res_en  = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_REQ;
        end
      end
      ST_EVAL2: begin
        res_d   = slow_code;
        res_en  = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_BUSY;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign rd_req  = (state_q == ST_REQ);
  assign done    = (state_q == ST_DONE);
  assign cap_idx = idx_q;
  assign result  = res_q;

endmodule

// File: rtl/nor_poll_decoder.sv
module nor_poll_decoder
  import nps_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbuf_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic [2:0]        result_o
);

  localparam int unsigned DEPTH = TOTAL_READS;
  localparam int unsigned IDX_W = $clog2(DEPTH + 1);

  logic                    launch;
  logic                    cap_en;
  logic [IDX_W-1:0]        cap_idx;
  logic [DEPTH*DATA_W-1:0] words;
  logic                    toggling;
  res_e                    fast_code;
  res_e                    slow_code;
  res_e                    result;
  logic [ADDR_W-1:0]       addr_q;
  logic                    wbuf_q;

  // Poll address and write-buffer flag are held for the whole evaluation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wbuf_q <= 1'b0;
    end else if (launch) begin
      addr_q <= addr_i;
      wbuf_q <= wbuf_i;
    end
  end

  nps_read_seq #(
    .N_FIRST (FIRST_READS),
    .N_TOTAL (TOTAL_READS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .rsp_valid (rsp_valid_i),
    .toggling  (toggling),
    .fast_code (fast_code),
    .slow_code (slow_code),
    .launch    (launch),
    .rd_req    (rd_req_o),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .done      (done_o),
    .result    (result)
  );

  nps_sample_bank #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cap_en),
    .wr_idx  (cap_idx),
    .wr_data (rsp_data_i),
    .words   (words)
  );

  nps_toggle_eval #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_eval (
    .words     (words),
    .wbuf      (wbuf_q),
    .toggling  (toggling),
    .fast_code (fast_code),
    .slow_code (slow_code)
  );

  assign rd_addr_o = addr_q;
  assign result_o  = result;

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rsp_valid_i,
  input logic              done_o,
  input logic [2:0]        result_o
);

  logic       pending_q;
  logic [2:0] nreq_q;

  // Outstanding-read tracker and per-evaluation request counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      nreq_q    <= '0;
    end else begin
      if (rd_req_o) begin
        pending_q <= 1'b1;
      end else if (rsp_valid_i) begin
        pending_q <= 1'b0;
      end
      if (done_o) begin
        nreq_q <= '0;
      end else if (rd_req_o) begin
        nreq_q <= nreq_q + 3'd1;
      end
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);                                         // R2
  AST_REQ_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !pending_q);                                        // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !done_o) |-> $stable(rd_addr_o));                  // R2
  AST_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (result_o == 3'd0 || result_o >= 3'd3)) |-> nreq_q == 3'd3); // R4
  AST_LONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (result_o == 3'd1 || result_o == 3'd2)) |-> nreq_q == 3'd5); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                             // R8
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> result_o <= 3'd4);                                    // R8
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !rd_req_o);                                           // R9

endmodule

bind nor_poll_decoder nps_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rsp_valid_i (rsp_valid_i),
  .done_o      (done_o),
  .result_o    (result_o)
);

// File: tb/nor_poll_decoder_bench.sv
module nor_poll_decoder_bench;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic        wb;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [15:0] w2;
    logic [15:0] w3;
    logic [15:0] w4;
    logic [2:0]  exp;
    logic [2:0]  nrd;
    logic [2:0]  lat;
  } vec_t;

  // Codes: 0 busy, 1 ready, 2 suspended, 3 timeout, 4 abort
  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd0, 3'd3, 3'd1}, // R6 busy
    '{1'b0, 16'h0060, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd3, 3'd3, 3'd2}, // R6 timeout
    '{1'b1, 16'h0042, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd4, 3'd3, 3'd1}, // R5 abort
    '{1'b1, 16'h0062, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd4, 3'd3, 3'd3}, // R5 over timeout
    '{1'b0, 16'h0042, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd0, 3'd3, 3'd1}, // R5 no flag
    '{1'b0, 16'h0040, 16'h0000, 16'h0000, 16'h0004, 16'h0004, 3'd1, 3'd5, 3'd1}, // R4 first pair only
    '{1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0000, 3'd2, 3'd5, 3'd2}, // R7 suspended
    '{1'b0, 16'h0000, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd1, 3'd5, 3'd4}, // R4 second pair only
    '{1'b0, 16'h0020, 16'h0020, 16'h0020, 16'h0020, 16'h0020, 3'd1, 3'd5, 3'd1}, // R6 no toggle
    '{1'b0, 16'h0040, 16'h0020, 16'h0040, 16'h0000, 16'h0000, 3'd0, 3'd3, 3'd7}, // R6 late bit5
    '{1'b0, 16'hFFBF, 16'hFFBF, 16'hFFBF, 16'h00F4, 16'hFF0C, 3'd1, 3'd5, 3'd2}  // R7 other bits
  };

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] addr_i;
  logic              wbuf_i;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rsp_valid_i;
  logic [DATA_W-1:0] rsp_data_i;
  logic              done_o;
  logic [2:0]        result_o;

  int  n_checks;
  int  n_errors;
  int  cycles;
  bit  wd_hit;

  nor_poll_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nor_poll_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .wbuf_i      (wbuf_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) wd_hit <= 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input vec_t v, input int k);
    case (k)
      0: return v.w0;
      1: return v.w1;
      2: return v.w2;
      3: return v.w3;
      default: return v.w4;
    endcase
  endfunction

  // Run one evaluation; options inject a mid-run start, a stray response,
  // or a start in the done cycle
  task automatic run(input vec_t v, input logic [ADDR_W-1:0] a, input bit mid_start,
                     input bit spur, input bit start_at_done, input string tag);
    int  nreads = 0;
    bit  fin = 0;
    bit  addr_ok = 1;
    int  done_hi = 0;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; wbuf_i = v.wb;
    @(negedge clk);
    start_i = 1'b0; addr_i = ~a; wbuf_i = ~v.wb;
    while (!fin && !wd_hit) begin
      if (done_o) begin
        fin = 1;
        check(result_o == v.exp, {tag, " result"}, result_o, v.exp);
        check(nreads == int'(v.nrd), {tag, " R4 R7 read count"}, nreads, v.nrd);
        if (start_at_done) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (!done_o) done_hi = 1;
        check(done_hi == 1, {tag, " R8 done one cycle"}, done_o, 0);
        begin
          bit quiet = 1;
          for (int k = 0; k < 6; k++) begin
            if (rd_req_o) quiet = 0;
            @(negedge clk);
          end
          check(quiet, {tag, " R9 no reads after done"}, !quiet, 0);
        end
      end else if (rd_req_o) begin
        if (rd_addr_o != a) addr_ok = 0;
        if (spur && nreads == 0) begin
          rsp_valid_i = 1'b1; rsp_data_i = 16'h0040;
        end
        for (int k = 0; k < int'(v.lat); k++) begin
          @(negedge clk);
          rsp_valid_i = 1'b0;
          if (mid_start && nreads == 1 && k == 0) start_i = 1'b1;
          else start_i = 1'b0;
          if (rd_addr_o != a) addr_ok = 0;
        end
        start_i = 1'b0;
        rsp_valid_i = 1'b1; rsp_data_i = word_of(v, nreads);
        nreads++;
        @(negedge clk);
        rsp_valid_i = 1'b0; rsp_data_i = 16'hxxxx;
      end else begin
        @(negedge clk);
      end
    end
    check(addr_ok, {tag, " R2 read address held"}, rd_addr_o, a);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; cycles = 0; wd_hit = 0;
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; wbuf_i = 1'b0;
    rsp_valid_i = 1'b0; rsp_data_i = '0;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && rd_req_o == 1'b0, "R1 reset outputs", {done_o, rd_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: stray response while idle
    rsp_valid_i = 1'b1; rsp_data_i = 16'h0040;
    @(negedge clk);
    rsp_valid_i = 1'b0;
    check(done_o == 1'b0 && rd_req_o == 1'b0, "R1 R3 idle after stray response",
          {done_o, rd_req_o}, 0);

    // Table walk, R10 through varied latencies
    for (int i = 0; i < NVEC; i++) begin
      run(TBL[i], 24'h100 + 24'(i * 24'h1111), 1'b0, 1'b0, 1'b0,
          $sformatf("vec%0d", i));
    end

    // R9: start pulses mid-run and in the done cycle
    run(TBL[6], 24'hABCDE, 1'b1, 1'b0, 1'b0, "R9 mid-run start");
    run(TBL[1], 24'h12345, 1'b0, 1'b0, 1'b1, "R9 start at done");
    // R3: stray response in the request cycle would change the outcome
    run('{1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0004, 3'd1, 3'd5, 3'd2},
        24'h777, 1'b0, 1'b1, 1'b0, "R3 stray in request cycle");
    // R10: long response latency
    run('{1'b0, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd0, 3'd3, 3'd7},
        24'h42, 1'b0, 1'b0, 1'b0, "R10 slow responses");

    check(!wd_hit, "watchdog", wd_hit, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule